// File: doc/BRIEF.md
# Multi-PHY Round-Robin Poll Sequencer

This block produces the address sequence that a multi-PHY cell-bus master puts on its 5-bit PHY address lines while polling the attached PHYs for status. A logical slot counter steps round-robin from 0 up to a programmable last-slot value and then returns to 0. Each logical slot number selects one entry of a writable translation table. The physical address stored in that entry is driven while the slot is active. Because of the table, the polled addresses need not be contiguous, need not start at zero, and may appear in any order.

A host configuration port loads the table entries and the last-slot value. A poll-enable level switches polling on and off. A one-cycle step strobe marks the start of each new poll slot. The transmit and receive sides each use their own instance, so each side has its own table and its own range.

Top module: `mphy_poll_seq`

## Requirements
- R1: After synchronous reset, table entry i holds the value i for i = 0..30, the last-slot value is 30 and `slot_idx` is 0. Stepping continuously with polling enabled then yields `phy_addr` 0, 1, ..., 30, 0, ...
- R2: While `poll_en` is low, `phy_addr` is 5'b11111 in the same cycle. From the first clock edge with `poll_en` low onward, `slot_idx` is 0.
- R3: While `poll_en` is high, every clock edge with `poll_step` high starts the next slot and raises `slot_idx` by one. At edges without `poll_step`, both `slot_idx` and `phy_addr` hold.
- R4: A step taken when `slot_idx` is at or above the effective last-slot value returns `slot_idx` to 0. This includes the case where the range was lowered below the current slot.
- R5: During logical slot N, `phy_addr` carries table entry N, not N itself.
- R6: A configuration write with `cfg_wr_sel` = 0 stores `cfg_wr_data` into table entry `cfg_wr_idx`. A write to index 31 changes no entry.
- R7: A configuration write with `cfg_wr_sel` = 1 stores the last-slot value. A stored value of 31 acts as 30.
- R8: The table entry is captured at the clock edge that starts a slot. A write to the entry of the slot in progress leaves `phy_addr` unchanged until a later slot reads that entry again. A write at the same edge as a step is not seen by the slot that this step starts.
- R9: When `poll_en` rises, the first active slot is logical slot 0. It carries entry 0 as the table stood one edge before.
- R10: With entries 0 to 7 set to 1, 3, 5, 7, 0, 2, 4, 6 and a last-slot value of 7, continuous stepping drives 1, 3, 5, 7, 0, 2, 4, 6 repeatedly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_sel | input | 1 | Write target: 0 = translation entry, 1 = last-slot value |
| cfg_wr_idx | input | 5 | Table entry index (0..30) |
| cfg_wr_data | input | 5 | Physical address or last-slot value to store |
| poll_en | input | 1 | Polling enable level |
| poll_step | input | 1 | Start the next poll slot at this edge |
| slot_idx | output | 5 | Current logical slot number |
| phy_addr | output | 5 | Physical address for the current slot, or all ones when idle |

## Verification
The bench goes after the wrap point in several forms:
- The last-slot value is lowered while the counter sits above it. A design that compared only for equality would run on through unused slots.
- Writing 31 as the range checks the clamp. A design without the clamp would poll slot 31, which has no table entry.

Table writes are aimed at the entry of the live slot and at the entry a step is about to load. A design that read the table combinationally would change the address mid-slot. Pulsing the enable checks two things: that idle forces the null address at once, and that re-enabling restarts at slot 0. A design that kept its position across idle would resume mid-sequence.

// File: rtl/mphy_poll_pkg.sv
package mphy_poll_pkg;

    localparam int PHY_AW = 5;

    typedef enum logic {
        CFG_XLAT  = 1'b0,
        CFG_RANGE = 1'b1
    } cfg_sel_e;

    typedef struct packed {
        logic [PHY_AW-1:0] lp;
        logic [PHY_AW-1:0] addr;
    } slot_state_t;

    function automatic int unsigned clamp_last(input int unsigned r, input int unsigned top);
        return (r > top) ? top : r;
    endfunction

    function automatic int unsigned next_slot(input int unsigned cur, input int unsigned last);
        return (cur >= last) ? 0 : cur + 1;
    endfunction

endpackage

// File: rtl/poll_xlat_table.sv
module poll_xlat_table #(
    parameter int AW    = mphy_poll_pkg::PHY_AW,
    parameter int N_ENT = (1 << AW) - 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_idx,
    input  logic [AW-1:0] wr_data,
    input  logic [AW-1:0] rd_idx,
    output logic [AW-1:0] rd_data
);

    logic [AW-1:0] ent_q [N_ENT];

    for (genvar e = 0; e < N_ENT; e++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst) begin
                ent_q[e] <= AW'(e);
            end else if (wr_en && (wr_idx == AW'(e))) begin
                ent_q[e] <= wr_data;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        for (int k = 0; k < N_ENT; k++) begin
            if (rd_idx == AW'(k)) begin
                rd_data = ent_q[k];
            end
        end
    end

endmodule

// File: rtl/poll_range_reg.sv
module poll_range_reg #(
    parameter int AW    = mphy_poll_pkg::PHY_AW,
    parameter int N_ENT = (1 << AW) - 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_data,
    output logic [AW-1:0] last_eff
);

    localparam int unsigned LAST_MAX = N_ENT - 1;

    logic [AW-1:0] last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            last_q <= AW'(LAST_MAX);
        end else if (wr_en) begin
            last_q <= wr_data;
        end
    end

    assign last_eff = AW'(mphy_poll_pkg::clamp_last(int'(last_q), LAST_MAX));

endmodule

// File: rtl/poll_slot_ctrl.sv
module poll_slot_ctrl #(
    parameter int AW = mphy_poll_pkg::PHY_AW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          poll_en,
    input  logic          poll_step,
    input  logic [AW-1:0] last_eff,
    input  logic [AW-1:0] tbl_data,
    output logic [AW-1:0] tbl_idx,
    output logic [AW-1:0] slot_idx,
    output logic [AW-1:0] phy_addr
);
    import mphy_poll_pkg::*;

    localparam logic [AW-1:0] NULL_ADDR = '1;

    slot_state_t st_q, st_d;
    logic [AW-1:0] nxt_lp;

    assign nxt_lp  = AW'(next_slot(int'(st_q.lp), int'(last_eff)));
    assign tbl_idx = poll_en ? nxt_lp : '0;

    always_comb begin
        st_d = st_q;
        if (!poll_en) begin
            st_d.lp   = '0;
            st_d.addr = tbl_data;
        end else if (poll_step) begin
            st_d.lp   = nxt_lp;
            st_d.addr = tbl_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign slot_idx = st_q.lp;
    assign phy_addr = poll_en ? st_q.addr : NULL_ADDR;

endmodule

// File: rtl/mphy_poll_seq.sv
module mphy_poll_seq (
    input  logic       clk,
    input  logic       rst,
    input  logic       cfg_wr_en,
    input  logic       cfg_wr_sel,
    input  logic [4:0] cfg_wr_idx,
    input  logic [4:0] cfg_wr_data,
    input  logic       poll_en,
    input  logic       poll_step,
    output logic [4:0] slot_idx,
    output logic [4:0] phy_addr
);
    import mphy_poll_pkg::*;

    localparam int AW    = PHY_AW;
    localparam int N_ENT = (1 << AW) - 1;

    cfg_sel_e      sel;
    logic          wr_tbl, wr_rng;
    logic [AW-1:0] last_eff;
    logic [AW-1:0] tbl_idx, tbl_data;

    assign sel    = cfg_sel_e'(cfg_wr_sel);
    assign wr_tbl = cfg_wr_en && (sel == CFG_XLAT);
    assign wr_rng = cfg_wr_en && (sel == CFG_RANGE);

    poll_xlat_table #(.AW(AW), .N_ENT(N_ENT)) u_tbl (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_tbl),
        .wr_idx  (cfg_wr_idx),
        .wr_data (cfg_wr_data),
        .rd_idx  (tbl_idx),
        .rd_data (tbl_data)
    );

    poll_range_reg #(.AW(AW), .N_ENT(N_ENT)) u_rng (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_rng),
        .wr_data  (cfg_wr_data),
        .last_eff (last_eff)
    );

    poll_slot_ctrl #(.AW(AW)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .poll_en   (poll_en),
        .poll_step (poll_step),
        .last_eff  (last_eff),
        .tbl_data  (tbl_data),
        .tbl_idx   (tbl_idx),
        .slot_idx  (slot_idx),
        .phy_addr  (phy_addr)
    );

endmodule

// File: rtl/mphy_poll_seq_chk.sv
module mphy_poll_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       poll_en,
    input logic       poll_step,
    input logic [4:0] slot_idx,
    input logic [4:0] phy_addr,
    input logic [4:0] last_eff
);

    AST_NULL_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        !poll_en |-> phy_addr == 5'h1F); // R2

    AST_IDLE_SLOT_ZERO: assert property (@(posedge clk) disable iff (rst)
        !poll_en |=> slot_idx == 5'd0); // R2

    AST_HOLD_SLOT: assert property (@(posedge clk) disable iff (rst)
        poll_en && !poll_step |=> slot_idx == $past(slot_idx)); // R3

    AST_HOLD_ADDR: assert property (@(posedge clk) disable iff (rst)
        poll_en && !poll_step |=> (!poll_en || $stable(phy_addr))); // R8

    AST_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        poll_en && poll_step && (slot_idx < last_eff) |=> slot_idx == $past(slot_idx) + 5'd1); // R3

    AST_WRAP: assert property (@(posedge clk) disable iff (rst)
        poll_en && poll_step && (slot_idx >= last_eff) |=> slot_idx == 5'd0); // R4

    AST_RANGE_CAP: assert property (@(posedge clk) disable iff (rst)
        last_eff <= 5'd30); // R7

    AST_IDX_BOUND: assert property (@(posedge clk) disable iff (rst)
        slot_idx <= 5'd30); // R4

endmodule

bind mphy_poll_seq mphy_poll_seq_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .poll_en   (poll_en),
    .poll_step (poll_step),
    .slot_idx  (slot_idx),
    .phy_addr  (phy_addr),
    .last_eff  (last_eff)
);

// File: tb/test_mphy_poll_seq.sv
`timescale 1ns/1ps
module test_mphy_poll_seq;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_wr_en = 1'b0, cfg_wr_sel = 1'b0;
    logic [4:0] cfg_wr_idx = '0, cfg_wr_data = '0;
    logic       poll_en = 1'b0, poll_step = 1'b0;
    logic [4:0] slot_idx, phy_addr;

    mphy_poll_seq i_mphy_poll_seq (
        .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_wr_sel(cfg_wr_sel),
        .cfg_wr_idx(cfg_wr_idx), .cfg_wr_data(cfg_wr_data),
        .poll_en(poll_en), .poll_step(poll_step),
        .slot_idx(slot_idx), .phy_addr(phy_addr)
    );

    always #2 clk = ~clk;

    typedef struct {
        logic [4:0] idx;
        logic [4:0] addr;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk = 0;
    int   n_err = 0;
    bit   done  = 1'b0;

    logic [4:0] m_tbl [31];
    logic [4:0] m_last;
    logic [4:0] m_lp;
    logic [4:0] m_addr;

    // Monitor: compares the design outputs against queued expectations at mid-cycle.
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_chk++;
            if (slot_idx !== e.idx || phy_addr !== e.addr) begin
                n_err++;
                $display("FAIL %s: slot_idx=%0d phy_addr=%0d expected slot_idx=%0d phy_addr=%0d",
                         e.tag, slot_idx, phy_addr, e.idx, e.addr);
            end
        end
    end

    // Driver: applies one cycle of stimulus, queues the expected outputs, then updates the model.
    task automatic cyc(input logic en, input logic st, input logic we, input logic sel,
                       input logic [4:0] idx, input logic [4:0] dat, input string tag);
        exp_t e;
        logic [4:0] eff, nxt;
        poll_en = en; poll_step = st;
        cfg_wr_en = we; cfg_wr_sel = sel; cfg_wr_idx = idx; cfg_wr_data = dat;
        e.idx  = m_lp;
        e.addr = en ? m_addr : 5'h1F;
        e.tag  = tag;
        exp_q.push_back(e);
        @(posedge clk);
        eff = (m_last > 5'd30) ? 5'd30 : m_last;
        if (!en) begin
            m_lp = 5'd0; m_addr = m_tbl[0];
        end else if (st) begin
            nxt = (m_lp >= eff) ? 5'd0 : m_lp + 5'd1;
            m_lp = nxt; m_addr = m_tbl[nxt];
        end
        if (we && !sel && idx < 5'd31) m_tbl[idx] = dat;
        if (we && sel) m_last = dat;
        #1;
    endtask

    task automatic run(input int n, input logic en, input logic st, input string tag);
        for (int i = 0; i < n; i++) cyc(en, st, 1'b0, 1'b0, 5'd0, 5'd0, tag);
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 31; i++) m_tbl[i] = 5'(i);
        m_last = 5'd30; m_lp = 5'd0; m_addr = 5'd0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state, then R2 idle output
        run(2, 1'b0, 1'b0, "R1");
        run(3, 1'b0, 1'b1, "R2");
        // R1 identity sequence over a full lap plus wrap
        run(34, 1'b1, 1'b1, "R1");
        // R2 disable mid-sequence: null at once, slot back to 0
        run(3, 1'b0, 1'b1, "R2");
        // R3 stepping with gaps
        for (int i = 0; i < 6; i++) begin
            cyc(1'b1, 1'b0, 1'b0, 1'b0, 5'd0, 5'd0, "R3");
            cyc(1'b1, 1'b0, 1'b0, 1'b0, 5'd0, 5'd0, "R3");
            cyc(1'b1, 1'b1, 1'b0, 1'b0, 5'd0, 5'd0, "R3");
        end
        // R10 program the 1,3,5,7,0,2,4,6 order with last slot 7
        run(1, 1'b0, 1'b0, "R10");
        cyc(1'b0, 1'b0, 1'b1, 1'b0, 5'd0, 5'd1, "R10");
        cyc(1'b0, 1'b0, 1'b1, 1'b0, 5'd1, 5'd3, "R10");
        cyc(1'b0, 1'b0, 1'b1, 1'b0, 5'd2, 5'd5, "R10");
        cyc(1'b0, 1'b0, 1'b1, 1'b0, 5'd3, 5'd7, "R10");
        cyc(1'b0, 1'b0, 1'b1, 1'b0, 5'd4, 5'd0, "R10");
        cyc(1'b0, 1'b0, 1'b1, 1'b0, 5'd5, 5'd2, "R10");
        cyc(1'b0, 1'b0, 1'b1, 1'b0, 5'd6, 5'd4, "R10");
        cyc(1'b0, 1'b0, 1'b1, 1'b0, 5'd7, 5'd6, "R10");
        cyc(1'b0, 1'b0, 1'b1, 1'b1, 5'd0, 5'd7, "R7");
        run(1, 1'b0, 1'b0, "R9");
        run(20, 1'b1, 1'b1, "R10");
        // R5 remap slot 2 to an address far from its index
        cyc(1'b1, 1'b1, 1'b1, 1'b0, 5'd2, 5'd29, "R5");
        run(10, 1'b1, 1'b1, "R5");
        // R8 write the live slot's entry without stepping, then step on
        run(1, 1'b1, 1'b0, "R8");
        cyc(1'b1, 1'b0, 1'b1, 1'b0, m_lp, 5'd17, "R8");
        run(2, 1'b1, 1'b0, "R8");
        run(9, 1'b1, 1'b1, "R8");
        // R8 write the entry a step is about to load, at that same edge
        cyc(1'b1, 1'b1, 1'b1, 1'b0, (m_lp >= 5'd7) ? 5'd0 : m_lp + 5'd1, 5'd22, "R8");
        run(10, 1'b1, 1'b1, "R8");
        // R4 lower the range below the current slot
        while (m_lp != 5'd6) cyc(1'b1, 1'b1, 1'b0, 1'b0, 5'd0, 5'd0, "R4");
        cyc(1'b1, 1'b0, 1'b1, 1'b1, 5'd0, 5'd2, "R4");
        run(8, 1'b1, 1'b1, "R4");
        // R7 a range of 31 acts as 30
        cyc(1'b1, 1'b0, 1'b1, 1'b1, 5'd0, 5'd31, "R7");
        run(34, 1'b1, 1'b1, "R7");
        // R6 write to index 31 changes nothing; write entry 30
        cyc(1'b1, 1'b0, 1'b1, 1'b0, 5'd31, 5'd9, "R6");
        cyc(1'b1, 1'b0, 1'b1, 1'b0, 5'd30, 5'd12, "R6");
        run(33, 1'b1, 1'b1, "R6");
        // R9 re-enable restarts at slot 0 with entry 0 updated while idle
        run(2, 1'b0, 1'b0, "R9");
        cyc(1'b0, 1'b0, 1'b1, 1'b0, 5'd0, 5'd25, "R9");
        run(4, 1'b1, 1'b1, "R9");
        run(1, 1'b1, 1'b0, "R9");
        run(1, 1'b0, 1'b0, "R9");
        run(1, 1'b0, 1'b0, "R9");

        @(negedge clk);
        #1;
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule